// File: doc/BRIEF.md
# I2C SCL Clock Timing Generator

This block turns a fast system clock into the SCL waveform of an I2C bus controller. A power-of-two prescaler divides the system clock. Two programmable counts, measured in prescaled periods, set how long SCL is held low and how long it is released high. The byte engine raises a request line to get clocks. The generator answers with a single-cycle pulse at the start of every low phase and at the start of every high phase, and the engine shifts data on those pulses. SCL is driven open-drain: the block only ever pulls the line low. While SCL is released, the generator samples the line, so a slave that holds SCL low stretches the high phase.

All timing comes from one 32-bit configuration word. The same block also holds a combinational helper. The helper takes a requested total divisor and returns a copy of the configuration word with the prescaler exponent and the two phase counts filled in. All other fields of the word are passed through unchanged. These other fields hold the bus-free, start-hold and setup timing, which this generator carries but does not use.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and while the request line has been low since the last idle point, `scl_drive_low` is 0 (SCL released) and neither edge pulse is raised.
- R2: Each low phase lasts (L+1)·2^B system cycles. L is the low count in configuration bits 15:12 and B is the prescaler exponent in bits 3:0.
- R3: When no slave stretches the clock, each high phase lasts (H+1)·2^B system cycles, where H is the high count in configuration bits 19:16.
- R4: A request seen at a clock edge while idle makes `scl_drive_low` rise right after that edge. The first phase is always a low phase.
- R5: `fall_tick` is high for exactly the first cycle of each low phase, and `rise_tick` is high for exactly the first cycle of each high phase.
- R6: During a high phase, a prescaled period whose last cycle sees `scl_in` low does not count toward the high count. Holding SCL low for S cycles from the start of the phase, with S a multiple of 2^B, lengthens the phase by exactly S cycles.
- R7: If the request drops, the current low phase and the following high phase still finish in full. SCL then stays released and no further `fall_tick` appears.
- R8: Helper exponent: with M = 2^(FIELD_W+1), a divisor D > M gives B = floor(log2((D−1)/M)) + 1. Otherwise B = 0. B is written to bits 3:0.
- R9: Helper counts: T = ceil(D/2^B), low = T/2 (truncated), high = T − low. Each count is then reduced by one unless it is already zero. The high count goes to bits 19:16 and the low count to bits 15:12, as whole 4-bit fields.
- R10: The helper output copies bits 31:20 and 11:4 of the configuration word unchanged.
- R11: With FIELD_W = 3 the helper uses M = 16. With the default FIELD_W = 4 it uses M = 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Request for SCL clocks from the byte engine |
| cfg_word | input | 32 | Timing configuration word |
| scl_in | input | 1 | Sampled SCL line level (already synchronized) |
| div_req | input | DIV_W | Requested total divisor for the helper |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| rise_tick | output | 1 | Pulse on the first cycle of a high phase |
| fall_tick | output | 1 | Pulse on the first cycle of a low phase |
| cfg_suggest | output | 32 | Configuration word with fields derived from div_req |

## Verification
The bench measures phase lengths for the extreme counts (0 and 15) and for several prescaler exponents. An off-by-one in the terminal-count compare would show up here as every phase being one prescaled period short or long. Stretch tests hold SCL low at the start of the high phase with and without prescaling. A design that keeps counting while the line is held would produce an unstretched high phase. The helper is checked on both sides of the exponent threshold (32 against 33), at 1 and at the largest divisor, and with 3-bit fields. A wrong log rounding would there give a neighbouring exponent, or counts that overflow their field. A stop request issued mid-low checks that the generator finishes the high phase and then parks with SCL released, instead of cutting the phase short or starting another low.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  typedef struct packed {
    logic [3:0] base;
    logic [3:0] high;
    logic [3:0] low;
  } scl_fields_t;

  // Derive prescaler exponent and phase counts from a total divisor.
  // fw is the phase field width; the max high+low sum is 2^(fw+1).
  function automatic scl_fields_t derive_fields(input logic [31:0] div,
                                                input int unsigned fw);
    logic [31:0] max_sum;
    logic [31:0] q;
    logic [31:0] b;
    logic [31:0] t;
    logic [31:0] lo;
    logic [31:0] hi;
    max_sum = 32'd2 << fw;
    b = 32'd0;
    q = 32'd0;
    if (div > max_sum) begin
      q = (div - 32'd1) >> (fw + 1);
      for (int i = 0; i < 32; i++) begin
        if (q[i]) b = 32'(i + 1);
      end
    end
    t  = (div + (32'd1 << b) - 32'd1) >> b;
    lo = t >> 1;
    hi = t - lo;
    if (hi != 32'd0) hi = hi - 32'd1;
    if (lo != 32'd0) lo = lo - 32'd1;
    derive_fields.base = b[3:0];
    derive_fields.high = hi[3:0];
    derive_fields.low  = lo[3:0];
  endfunction

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick
);
  localparam int CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  assign mask = ~({CNT_W{1'b1}} << exp_sel);
  assign tick = en && (cnt == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_timing_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic               scl_in,
  input  logic [FIELD_W-1:0] high_cnt,
  input  logic [FIELD_W-1:0] low_cnt,
  output phase_e             state,
  output logic [FIELD_W-1:0] ph_cnt,
  output logic               busy,
  output logic               scl_drive_low,
  output logic               rise_tick,
  output logic               fall_tick
);
  logic low_done;
  logic high_step;
  logic high_done;

  assign busy          = (state != PH_IDLE);
  assign scl_drive_low = (state == PH_LOW);
  assign low_done      = tick && (ph_cnt == low_cnt);
  assign high_step     = tick && scl_in;
  assign high_done     = high_step && (ph_cnt == high_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= PH_IDLE;
      ph_cnt    <= '0;
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
    end else begin
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
      case (state)
        PH_IDLE: begin
          ph_cnt <= '0;
          if (run) begin
            state     <= PH_LOW;
            fall_tick <= 1'b1;
          end
        end
        PH_LOW: begin
          if (low_done) begin
            state     <= PH_HIGH;
            ph_cnt    <= '0;
            rise_tick <= 1'b1;
          end else if (tick) begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (high_done) begin
            ph_cnt <= '0;
            if (run) begin
              state     <= PH_LOW;
              fall_tick <= 1'b1;
            end else begin
              state <= PH_IDLE;
            end
          end else if (high_step) begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        end
        default: begin
          state  <= PH_IDLE;
          ph_cnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/scl_div_helper.sv
module scl_div_helper
  import scl_timing_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int DIV_W   = 16
) (
  input  logic [DIV_W-1:0] div_req,
  input  logic [11:0]      keep_hi,
  input  logic [7:0]       keep_mid,
  output logic [3:0]       fld_base,
  output logic [3:0]       fld_high,
  output logic [3:0]       fld_low,
  output logic [31:0]      cfg_out
);
  scl_fields_t f;

  assign f        = derive_fields(32'(div_req), FIELD_W);
  assign fld_base = f.base;
  assign fld_high = f.high;
  assign fld_low  = f.low;
  assign cfg_out  = {keep_hi, f.high, f.low, keep_mid, f.base};
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int DIV_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [31:0]      cfg_word,
  input  logic             scl_in,
  input  logic [DIV_W-1:0] div_req,
  output logic             scl_drive_low,
  output logic             rise_tick,
  output logic             fall_tick,
  output logic [31:0]      cfg_suggest
);
  localparam int EXP_W = 4;

  logic               pre_tick;
  logic               busy;
  phase_e             ph_state;
  logic [FIELD_W-1:0] ph_cnt;
  logic [3:0]         fld_base;
  logic [3:0]         fld_high;
  logic [3:0]         fld_low;

  scl_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (busy),
    .exp_sel (cfg_word[EXP_W-1:0]),
    .tick    (pre_tick)
  );

  scl_phase_fsm #(.FIELD_W(FIELD_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .tick          (pre_tick),
    .scl_in        (scl_in),
    .high_cnt      (cfg_word[16 +: FIELD_W]),
    .low_cnt       (cfg_word[12 +: FIELD_W]),
    .state         (ph_state),
    .ph_cnt        (ph_cnt),
    .busy          (busy),
    .scl_drive_low (scl_drive_low),
    .rise_tick     (rise_tick),
    .fall_tick     (fall_tick)
  );

  scl_div_helper #(.FIELD_W(FIELD_W), .DIV_W(DIV_W)) u_help (
    .div_req  (div_req),
    .keep_hi  (cfg_word[31:20]),
    .keep_mid (cfg_word[11:4]),
    .fld_base (fld_base),
    .fld_high (fld_high),
    .fld_low  (fld_low),
    .cfg_out  (cfg_suggest)
  );
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk
  import scl_timing_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int DIV_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic               scl_in,
  input logic               scl_drive_low,
  input logic               rise_tick,
  input logic               fall_tick,
  input logic               pre_tick,
  input phase_e             ph_state,
  input logic [FIELD_W-1:0] ph_cnt,
  input logic [FIELD_W-1:0] low_cfg,
  input logic [3:0]         base_cfg,
  input logic [DIV_W-1:0]   div_req,
  input logic [3:0]         fld_base,
  input logic [3:0]         fld_high,
  input logic [3:0]         fld_low
);
  logic [19:0] low_run;
  logic [19:0] exp_low;
  logic [31:0] achieved;

  assign exp_low  = (20'(low_cfg) + 20'd1) << base_cfg;
  assign achieved = (32'(fld_high) + 32'(fld_low) + 32'd2) << fld_base;

  always_ff @(posedge clk) begin
    if (!rst_n)             low_run <= '0;
    else if (scl_drive_low) low_run <= low_run + 20'd1;
    else                    low_run <= '0;
  end

  // R2
  low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> (low_run == exp_low));

  // R5
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> fall_tick);

  // R5
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> rise_tick);

  // R6
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_state == PH_HIGH && pre_tick && !scl_in)
      |=> (ph_state == PH_HIGH && ph_cnt == $past(ph_cnt)));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_state == PH_IDLE && !run) |=> (!fall_tick && !scl_drive_low));

  // R9
  helper_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_req != '0) |-> (achieved >= 32'(div_req)));
endmodule

bind scl_timing_gen scl_timing_chk #(.FIELD_W(FIELD_W), .DIV_W(DIV_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .run           (run),
  .scl_in        (scl_in),
  .scl_drive_low (scl_drive_low),
  .rise_tick     (rise_tick),
  .fall_tick     (fall_tick),
  .pre_tick      (pre_tick),
  .ph_state      (ph_state),
  .ph_cnt        (ph_cnt),
  .low_cfg       (cfg_word[12 +: FIELD_W]),
  .base_cfg      (cfg_word[3:0]),
  .div_req       (div_req),
  .fld_base      (fld_base),
  .fld_high      (fld_high),
  .fld_low       (fld_low)
);

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        hold_low = 1'b0;
  logic [15:0] div_req = '0;
  logic        scl_drive_low, rise_tick, fall_tick;
  logic [31:0] cfg_suggest;
  logic        scl_in;

  logic [31:0] cfg3 = '0;
  logic [15:0] div3 = '0;
  logic        drv3, rt3, ft3;
  logic [31:0] sug3;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  assign scl_in = ~scl_drive_low & ~hold_low;

  scl_timing_gen #(.FIELD_W(4), .DIV_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_word(cfg_word), .scl_in(scl_in),
    .div_req(div_req), .scl_drive_low(scl_drive_low), .rise_tick(rise_tick),
    .fall_tick(fall_tick), .cfg_suggest(cfg_suggest));

  scl_timing_gen #(.FIELD_W(3), .DIV_W(16)) dut3 (
    .clk(clk), .rst_n(rst_n), .run(1'b0), .cfg_word(cfg3), .scl_in(1'b1),
    .div_req(div3), .scl_drive_low(drv3), .rise_tick(rt3),
    .fall_tick(ft3), .cfg_suggest(sug3));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_cfg(input logic [31:0] cfg, input int d, input int maxsum);
    int b = 0;
    int q, t, lo, hi;
    logic [31:0] r;
    if (d > maxsum) begin
      q = (d - 1) / maxsum;
      while ((q >> b) != 0) b++;
    end
    t  = (d + (1 << b) - 1) / (1 << b);
    lo = t / 2;
    hi = t - lo;
    if (hi > 0) hi--;
    if (lo > 0) lo--;
    r = cfg;
    r[19:16] = hi[3:0];
    r[15:12] = lo[3:0];
    r[3:0]   = b[3:0];
    return r;
  endfunction

  // Called at the negedge of the first low cycle.
  task automatic run_cycle(input int s, output int lo_len, output int hi_len, output bit rt_ok);
    lo_len = 0;
    while (scl_drive_low) begin lo_len++; @(negedge clk); end
    rt_ok = rise_tick;
    hi_len = 0;
    hold_low = (s > 0);
    while (!scl_drive_low) begin
      hi_len++;
      @(negedge clk);
      if (hi_len == s) hold_low = 1'b0;
    end
  endtask

  task automatic test_cfg(input logic [31:0] cfg, input int s);
    int b, h, l, lo_len, hi_len, exp_lo, exp_hi, bad;
    bit rt_ok;
    b = int'(cfg[3:0]); h = int'(cfg[19:16]); l = int'(cfg[15:12]);
    exp_lo = (l + 1) << b;
    exp_hi = ((h + 1) << b) + ((s >> b) << b);
    cfg_word = cfg;
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    // R4: low starts right after the request edge, with a fall pulse
    check(fall_tick && scl_drive_low, "R4", {fall_tick, scl_drive_low}, 3);
    run_cycle(s, lo_len, hi_len, rt_ok);
    check(lo_len == exp_lo, "R2", lo_len, exp_lo);
    check(hi_len == exp_hi, s > 0 ? "R6" : "R3", hi_len, exp_hi);
    check(rt_ok, "R5 rise", rt_ok, 1);
    check(fall_tick, "R5 fall", fall_tick, 1);
    run = 1'b0;
    run_cycle(0, lo_len, hi_len, rt_ok);
    check(0, "unreachable", 0, 0);
  endtask

  task automatic test_stop(input logic [31:0] cfg);
    int b, h, l, lo_len, exp_lo, exp_hi, bad;
    b = int'(cfg[3:0]); h = int'(cfg[19:16]); l = int'(cfg[15:12]);
    exp_lo = (l + 1) << b;
    exp_hi = (h + 1) << b;
    cfg_word = cfg;
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    lo_len = 0;
    while (scl_drive_low) begin lo_len++; @(negedge clk); end
    check(lo_len == exp_lo, "R7 low finishes", lo_len, exp_lo);
    bad = 0;
    for (int k = 0; k < exp_hi + 20; k++) begin
      if (scl_drive_low || fall_tick) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R7 parks released", bad, 0);
  endtask

  task automatic test_help(input logic [31:0] cfg, input int d);
    logic [31:0] e;
    cfg_word = cfg;
    div_req = 16'(d);
    #1;
    e = model_cfg(cfg, d, 32);
    check(cfg_suggest == e, "R8/R9/R10 helper", cfg_suggest, e);
  endtask

  task automatic test_help3(input logic [31:0] cfg, input int d);
    logic [31:0] e;
    cfg3 = cfg;
    div3 = 16'(d);
    #1;
    e = model_cfg(cfg, d, 16);
    check(sug3 == e, "R11 helper 3-bit", sug3, e);
  endtask

  task automatic full_run(input logic [31:0] cfg, input int s);
    int b, h, l, lo_len, hi_len, exp_lo, exp_hi;
    bit rt_ok;
    b = int'(cfg[3:0]); h = int'(cfg[19:16]); l = int'(cfg[15:12]);
    exp_lo = (l + 1) << b;
    exp_hi = ((h + 1) << b) + ((s >> b) << b);
    cfg_word = cfg;
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    check(fall_tick && scl_drive_low, "R4", {fall_tick, scl_drive_low}, 3);
    run_cycle(s, lo_len, hi_len, rt_ok);
    check(lo_len == exp_lo, "R2", lo_len, exp_lo);
    check(hi_len == exp_hi, s > 0 ? "R6" : "R3", hi_len, exp_hi);
    check(rt_ok, "R5 rise", rt_ok, 1);
    check(fall_tick, "R5 fall", fall_tick, 1);
    run = 1'b0;
    while (scl_drive_low) @(negedge clk);
    for (int k = 0; k < exp_hi + 2; k++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rc;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: released after reset
    check(!scl_drive_low && !rise_tick && !fall_tick, "R1 reset", scl_drive_low, 0);
    begin
      int act = 0;
      for (int k = 0; k < 10; k++) begin
        if (scl_drive_low || rise_tick || fall_tick) act++;
        @(negedge clk);
      end
      check(act == 0, "R1 idle", act, 0);
    end

    full_run(32'h0000_0000, 0);
    full_run(32'h000F_F000, 0);
    full_run(32'h0002_5003, 0);
    for (int i = 0; i < 6; i++) begin
      rc = $urandom;
      rc[3:0] = 4'($urandom_range(0, 3));
      full_run(rc, 0);
    end

    // R6: clock stretching, unprescaled and prescaled
    full_run(32'h0003_2000, 5);
    full_run(32'h0001_1002, 8);

    test_stop(32'h0004_3001);

    // R8/R9/R10 helper, directed then random
    test_help(32'hABC0_0FF0, 1);
    test_help(32'h1230_0450, 32);
    test_help(32'hFFF0_0FF0, 33);
    test_help(32'h0000_0000, 100);
    test_help(32'h5A5A_5A5A, 65535);
    for (int i = 0; i < 20; i++) test_help($urandom, int'($urandom_range(1, 65535)));
    // R11: 3-bit fields
    test_help3(32'h0000_0000, 16);
    test_help3(32'hF0F0_F0F0, 17);
    test_help3(32'h1234_5678, 50);
    test_help3(32'h0000_0000, 65535);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule